// File: doc/BRIEF.md
# Host Bootstrap Program Loader

After reset this block keeps a processor core parked in a boot phase and fills its program memory over the host byte port. The host writes the three bytes of each 24-bit program word to three transmit byte locations (high, middle, low). Bytes merge by bitwise OR into a word accumulator. A write to the low byte completes the word and stores it at the next program address, starting from 0.

Once the configured number of words has been stored (512 by default), the block leaves the boot phase. It raises a one-cycle start pulse that releases the core. During the boot phase it also blocks the normal host handshake: low-byte transmit writes and low-byte receive reads do not reach the handshake logic. After release those strobes pass straight through and no further program writes occur.

Top module: `host_boot_loader`

## Requirements
- R1: While reset is asserted, `booting` is 1, `pm_we` and `run_start` are 0, and the next program address is 0.
- R2: `host_sel` codes are 0 for the high byte, 1 for the middle byte, 2 for the low byte, and 3 for a write that is ignored. A high write ORs `data<<16` into the accumulator, a middle write ORs `data<<8`, and a low write ORs `data` and commits the word.
- R3: The first byte of each word clears the accumulator before it is merged. Every low-byte write makes the next byte the first byte of a new word. A repeated write to the same byte position within one word ORs with the earlier value.
- R4: Each byte written is stored in its own transmit register (`tx_hi`, `tx_mid`, `tx_lo`). If a word's first byte goes to the middle location, it is also copied into `tx_hi`. If it goes to the low location, it is also copied into `tx_hi` and `tx_mid`.
- R5: While booting, each commit produces exactly one `pm_we` cycle, one clock after the low-byte write. `pm_data` carries the assembled word and `pm_addr` carries consecutive addresses starting at 0.
- R6: The commit that stores word number BOOT_WORDS-1 also clears `booting`, in the same cycle as its `pm_we`. `run_start` is 1 for exactly that one cycle.
- R7: While booting, `pass_wr` and `pass_rd` stay 0. After release, `pass_wr` follows a low-byte write strobe combinationally and `pass_rd` follows `host_rd_low`.
- R8: After release, low-byte writes produce no `pm_we`.
- R9: A write with `host_sel` = 3 leaves the accumulator and the first-byte state unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host byte write strobe |
| host_sel | input | 2 | Byte location: 0 high, 1 middle, 2 low, 3 none |
| host_data | input | BYTE_W | Host write byte |
| host_rd_low | input | 1 | Host read strobe of the low receive byte |
| tx_hi | output | BYTE_W | High transmit byte register |
| tx_mid | output | BYTE_W | Middle transmit byte register |
| tx_lo | output | BYTE_W | Low transmit byte register |
| pm_we | output | 1 | Program memory write enable |
| pm_addr | output | ADDR_W | Program memory write address |
| pm_data | output | 3*BYTE_W | Program memory write data |
| booting | output | 1 | High during the load phase |
| run_start | output | 1 | One-cycle pulse when the core is released |
| pass_wr | output | 1 | Low-byte write forwarded to the handshake logic |
| pass_rd | output | 1 | Low receive read forwarded to the handshake logic |

## Verification
The bench builds the loader with BOOT_WORDS = 8 and keeps the default address and byte widths. This makes the release after the last word, the start pulse and the behaviour after release reachable within a few dozen writes. The eight commits are spread across every first-byte position: high-first, middle-first, low-first, repeated high bytes and an ignored write between bytes. As a result, the accumulator clearing and the transmit-register copies are each covered while the address steps from 0 to 7.

// File: rtl/host_boot_loader.sv
module host_boot_loader #(
  parameter int ADDR_W     = 9,
  parameter int BYTE_W     = 8,
  parameter int BOOT_WORDS = 512
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_wr,
  input  logic [1:0]          host_sel,
  input  logic [BYTE_W-1:0]   host_data,
  input  logic                host_rd_low,
  output logic [BYTE_W-1:0]   tx_hi,
  output logic [BYTE_W-1:0]   tx_mid,
  output logic [BYTE_W-1:0]   tx_lo,
  output logic                pm_we,
  output logic [ADDR_W-1:0]   pm_addr,
  output logic [3*BYTE_W-1:0] pm_data,
  output logic                booting,
  output logic                run_start,
  output logic                pass_wr,
  output logic                pass_rd
);
  localparam int WORD_W = 3 * BYTE_W;
  localparam int CNT_W  = $clog2(BOOT_WORDS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BOOT_WORDS - 1);

  logic              first;
  logic [WORD_W-1:0] acc;
  logic [CNT_W-1:0]  cnt;

  wire wr_hi  = host_wr && host_sel == 2'd0;
  wire wr_mid = host_wr && host_sel == 2'd1;
  wire wr_lo  = host_wr && host_sel == 2'd2;

  wire [WORD_W-1:0] acc_base = first ? '0 : acc;
  wire [WORD_W-1:0] byte_in  = WORD_W'(host_data);
  wire [WORD_W-1:0] merged   = wr_hi  ? (acc_base | (byte_in << (2*BYTE_W))) :
                               wr_mid ? (acc_base | (byte_in << BYTE_W)) :
                                        (acc_base | byte_in);

  assign pass_wr = wr_lo && !booting;
  assign pass_rd = host_rd_low && !booting;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      booting   <= 1'b1;
      first     <= 1'b1;
      acc       <= '0;
      cnt       <= '0;
      pm_we     <= 1'b0;
      pm_addr   <= '0;
      pm_data   <= '0;
      run_start <= 1'b0;
      tx_hi     <= '0;
      tx_mid    <= '0;
      tx_lo     <= '0;
    end else begin
      pm_we     <= 1'b0;
      run_start <= 1'b0;
      if (wr_hi) begin
        acc   <= merged;
        tx_hi <= host_data;
        first <= 1'b0;
      end
      if (wr_mid) begin
        acc    <= merged;
        tx_mid <= host_data;
        if (first) tx_hi <= host_data;
        first  <= 1'b0;
      end
      if (wr_lo) begin
        tx_lo <= host_data;
        if (first) begin
          tx_hi  <= host_data;
          tx_mid <= host_data;
        end
        first <= 1'b1;
        if (booting) begin
          pm_we   <= 1'b1;
          pm_addr <= ADDR_W'(cnt);
          pm_data <= merged;
          acc     <= '0;
          cnt     <= cnt + 1'b1;
          if (cnt == LAST) begin
            booting   <= 1'b0;
            run_start <= 1'b1;
          end
        end else begin
          acc <= merged;
        end
      end
    end
  end
endmodule

// File: rtl/host_boot_loader_chk.sv
module host_boot_loader_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       host_wr,
  input logic [1:0] host_sel,
  input logic       pm_we,
  input logic       booting,
  input logic       run_start,
  input logic       pass_wr,
  input logic       pass_rd
);
  // R5
  commit_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pm_we |-> $past(host_wr && host_sel == 2'd2 && booting));
  // R6
  start_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_start |-> (!booting && $past(booting)));
  // R6
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_start |=> !run_start);
  // R7
  gate_boot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    booting |-> (!pass_wr && !pass_rd));
  // R8
  no_load_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !booting |=> !pm_we);
endmodule

bind host_boot_loader host_boot_loader_chk chk_i (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
  .pm_we(pm_we), .booting(booting), .run_start(run_start),
  .pass_wr(pass_wr), .pass_rd(pass_rd)
);

// File: tb/host_boot_loader_tb.sv
`timescale 1ns/1ps
module host_boot_loader_tb_top;
  logic clk = 0, rst_n = 0, host_wr = 0, host_rd_low = 0;
  logic [1:0] host_sel = 2'd3;
  logic [7:0] host_data = '0;
  logic [7:0] tx_hi, tx_mid, tx_lo;
  logic pm_we, booting, run_start, pass_wr, pass_rd;
  logic [8:0] pm_addr;
  logic [23:0] pm_data;
  int tests = 0, fails = 0, commits = 0;
  logic seen_pass;

  always #10 clk = ~clk;

  host_boot_loader #(.ADDR_W(9), .BYTE_W(8), .BOOT_WORDS(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
    .host_data(host_data), .host_rd_low(host_rd_low), .tx_hi(tx_hi),
    .tx_mid(tx_mid), .tx_lo(tx_lo), .pm_we(pm_we), .pm_addr(pm_addr),
    .pm_data(pm_data), .booting(booting), .run_start(run_start),
    .pass_wr(pass_wr), .pass_rd(pass_rd));

  // {sel, data, commit, word}
  localparam logic [34:0] VEC [12] = '{
    {2'd0, 8'h12, 1'b0, 24'h0},
    {2'd1, 8'h34, 1'b0, 24'h0},
    {2'd2, 8'h56, 1'b1, 24'h123456},
    {2'd2, 8'hA5, 1'b1, 24'h0000A5},
    {2'd1, 8'h3C, 1'b0, 24'h0},
    {2'd2, 8'h01, 1'b1, 24'h003C01},
    {2'd0, 8'h0F, 1'b0, 24'h0},
    {2'd0, 8'hF0, 1'b0, 24'h0},
    {2'd2, 8'h00, 1'b1, 24'hFF0000},
    {2'd0, 8'h11, 1'b0, 24'h0},
    {2'd3, 8'hFF, 1'b0, 24'h0},
    {2'd2, 8'h22, 1'b1, 24'h110022}
  };

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [7:0] d);
    @(negedge clk);
    host_sel = sel; host_data = d; host_wr = 1;
    #2 seen_pass = pass_wr;
    @(negedge clk);
    host_wr = 0; host_sel = 2'd3;
  endtask

  task automatic commit_chk(string req, logic [23:0] word);
    check(req, {31'd0, pm_we}, 1);
    check(req, {23'd0, pm_addr}, commits);
    check(req, {8'd0, pm_data}, {8'd0, word});
    commits++;
  endtask

  initial begin
    #2_000_000;
    tests++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check("R1 booting", {31'd0, booting}, 1);
    check("R1 pm_we", {31'd0, pm_we}, 0);
    check("R1 run_start", {31'd0, run_start}, 0);
    rst_n = 1;

    // R2 R3 R5 R9
    for (int i = 0; i < 12; i++) begin
      wr(VEC[i][34:33], VEC[i][32:25]);
      if (VEC[i][24]) commit_chk("R2/R3/R5/R9 commit", VEC[i][23:0]);
      else check("R5 no write", {31'd0, pm_we}, 0);
      check("R7 pass_wr boot", {31'd0, seen_pass}, 0);
    end

    // R4
    wr(2'd1, 8'h5A);
    check("R4 mid-first hi", {24'd0, tx_hi}, 32'h5A);
    check("R4 mid-first mid", {24'd0, tx_mid}, 32'h5A);
    wr(2'd2, 8'h01);
    commit_chk("R4 word", 24'h005A01);
    check("R4 lo", {24'd0, tx_lo}, 32'h01);

    wr(2'd0, 8'h80);
    check("R4 hi", {24'd0, tx_hi}, 32'h80);
    wr(2'd2, 8'h00);
    commit_chk("R5 word", 24'h800000);
    check("R6 still booting", {31'd0, booting}, 1);

    // R7
    @(negedge clk); host_rd_low = 1; #2;
    check("R7 pass_rd boot", {31'd0, pass_rd}, 0);
    @(negedge clk); host_rd_low = 0;

    // R4 R6
    wr(2'd2, 8'hC3);
    commit_chk("R6 last word", 24'h0000C3);
    check("R4 lo-first hi", {24'd0, tx_hi}, 32'hC3);
    check("R4 lo-first mid", {24'd0, tx_mid}, 32'hC3);
    check("R6 booting", {31'd0, booting}, 0);
    check("R6 run_start", {31'd0, run_start}, 1);
    @(negedge clk);
    check("R6 pulse", {31'd0, run_start}, 0);

    // R7 R8
    wr(2'd2, 8'h44);
    check("R8 no pm_we", {31'd0, pm_we}, 0);
    check("R7 pass_wr run", {31'd0, seen_pass}, 1);
    @(negedge clk); host_rd_low = 1; #2;
    check("R7 pass_rd run", {31'd0, pass_rd}, 1);
    @(negedge clk); host_rd_low = 0;
    check("R8 booting stays", {31'd0, booting}, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule